// File: doc/BRIEF.md
# Warm Reset Controller with Cause Capture

This block owns the shared, active-low warm reset line of a microcontroller. Five internal sources can ask for a warm reset: oscillator failure, PLL slip, watchdog or debugger, CPU self-test and software. Any of them makes the block pull the line low for a short, fixed stretch. Releasing the power-on reset starts a much longer stretch. The pad is open drain. The block has a single drive-low control and never drives the line high.

The same line is read back through a two-flop synchroniser and a glitch filter. This lets an outside agent request a reset by pulling the line low. The filter counts consecutive low samples and applies a fixed rule:
- A pulse shorter than `FILT_MIN` samples is dropped.
- A pulse of `FILT_MIN` to `FILT_MAX-1` samples is accepted when it ends.
- A pulse of `FILT_MAX` samples or more is accepted at its `FILT_MAX`-th sample, while it is still held.

While the block drives the line itself, and for `BLANK_CYC` cycles afterwards, the filter ignores the read-back.

Every cause sets its own sticky flag. The flags live in two status words, and software clears them by writing ones. The chip-wide reset output `sys_rst_n` asserts at once whenever the line is driven or held low. It deasserts through a two-flop synchroniser. One clock serves as both the oscillator and the peripheral clock. All lengths are given in its cycles.

Top module: `warm_rst_ctrl`

## Requirements
- R1: `pin_drv_low` is 1 only while a stretch is running and is 0 at all other times; the block has no output that drives the line high.
- R2: While `rst_n` is low, `pin_drv_low` is 1. After `rst_n` is sampled high, `pin_drv_low` falls at the `LONG_CYC`-th rising edge.
- R3: An internal request sampled at a rising edge sets `pin_drv_low` after that edge. The line then stays driven for `SHORT_CYC` cycles.
- R4: A request that arrives during a running stretch sets the remaining length to the larger of what is left and `SHORT_CYC`, so the stretch is restarted or kept, never shortened.
- R5: An external low of fewer than `FILT_MIN` consecutive samples has no effect. No drive, no flag and no `sys_rst_n` pulse follow.
- R6: An external low of `FILT_MIN` to `FILT_MAX-1` samples is accepted after it ends and causes one short stretch.
- R7: An external low of `FILT_MAX` samples or more starts one short stretch while it is still held. `sys_rst_n` stays low until the line is released.
- R8: The block's own drive, and the `BLANK_CYC` cycles after it ends, are never read as an external request. A lone stretch therefore never re-triggers.
- R9: Each cause sets its own flag. In `glob_flags`, bit 0 is oscillator fail and bit 1 is PLL slip. In `exc_flags`, bit 0 is power-up, bit 1 is watchdog/debugger, bit 2 is CPU self-test, bit 3 is software and bit 4 is external.
- R10: Flags are sticky and survive warm resets. Power-on reset (`rst_n` low) clears every flag except `exc_flags` bit 0, which it sets.
- R11: `clr_wr` clears the flags of the word chosen by `clr_sel` (0 = global, 1 = exception) wherever `clr_data` holds a 1. A flag set in the same cycle stays set.
- R12: `sys_rst_n` goes low without waiting for a clock edge when the line is driven or held low. It returns high at the second rising edge after both have ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the filter and all counters |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| req_osc_fail | input | 1 | Oscillator failure request |
| req_pll_slip | input | 1 | PLL slip request |
| req_wdog_dbg | input | 1 | Watchdog or debugger request |
| req_cpu_test | input | 1 | CPU self-test reset request |
| req_soft | input | 1 | Software reset request |
| pin_in | input | 1 | Read-back of the reset pad |
| pin_drv_low | output | 1 | Open-drain enable: 1 pulls the pad low, 0 releases it |
| sys_rst_n | output | 1 | Chip-wide warm reset, active low |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_sel | input | 1 | Word select: 0 global, 1 exception |
| clr_data | input | STAT_W | Bits to clear |
| glob_flags | output | STAT_W | Global cause flags |
| exc_flags | output | STAT_W | Exception cause flags |

## Verification
Three cases are the hardest to reach from the ports:
- A request that lands in the middle of a stretch.
- An external low that is still being held after the block has started driving.
- The block's own read-back, which looks exactly like an external pulse.

The bench models the pad as a wired-AND of `pin_drv_low` and its own pull-down, so every stretch feeds back into the filter just as the pad would. It then measures drive and reset lengths in cycles. It also injects a second request five cycles into a stretch and another one deep into the power-on stretch. Finally, it holds the external low beyond `FILT_MAX` and counts drive cycles that overlap the external hold.

// File: rtl/wrc_pkg.sv
// Package: bit positions of the cause flags shared by the controller and its users.
// Assumes status words are at least 5 bits wide.
package wrc_pkg;
    localparam int G_OSC  = 0;  // global word: oscillator failure
    localparam int G_PLL  = 1;  // global word: PLL slip
    localparam int E_PWR  = 0;  // exception word: power-up
    localparam int E_WDOG = 1;  // exception word: watchdog / debugger
    localparam int E_CPU  = 2;  // exception word: CPU self-test
    localparam int E_SOFT = 3;  // exception word: software
    localparam int E_EXT  = 4;  // exception word: external pin
    localparam int N_INT  = 5;  // number of internal request inputs
endpackage

// File: rtl/wrc_stretch.sv
// Pulse stretcher: holds the open-drain enable for LONG_CYC cycles after
// power-on release, and for at least SHORT_CYC cycles after any trigger.
// Assumes LONG_CYC and SHORT_CYC are both nonzero.
module wrc_stretch #(
    parameter int unsigned LONG_CYC  = 2228,
    parameter int unsigned SHORT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic drive_o
);
    localparam int unsigned MAXL = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int unsigned CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          drv_q;
    logic [CW-1:0] run_q;

    // Next count: decrement, then lift to the short length on a trigger if lower.
    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        if (trig_i && (cnt_d < SHORT_V))
            cnt_d = SHORT_V;
    end

    // Counter and registered drive enable; power-on loads the long stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= LONG_V;
            drv_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            drv_q <= (cnt_d != '0);
        end
    end

    assign drive_o = drv_q;

    // Checker counter: cycles the enable has been high in the current run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (drv_q)
            run_q <= (run_q == '1) ? run_q : run_q + 1'b1;
        else
            run_q <= '0;
    end

    p_trig_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> drv_q);
    p_min_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_q) |-> (run_q >= SHORT_V));
endmodule

// File: rtl/wrc_pin_filter.sv
// Pin read-back filter: synchronises the pad, counts consecutive low samples
// and flags an accepted external request. Lows under FILT_MIN are dropped,
// lows ending between FILT_MIN and FILT_MAX-1 are accepted at their end,
// lows reaching FILT_MAX are accepted at once and must go high to re-arm.
// While drive_i is high and BLANK_CYC cycles after, the read-back is ignored.
// Assumes 0 < FILT_MIN <= FILT_MAX and BLANK_CYC >= 3 (synchroniser depth + 1).
module wrc_pin_filter #(
    parameter int unsigned FILT_MIN  = 100,
    parameter int unsigned FILT_MAX  = 400,
    parameter int unsigned BLANK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic drive_i,
    output logic hit_o,
    output logic held_o
);
    localparam int unsigned LW = $clog2(FILT_MAX + 1);
    localparam int unsigned BW = $clog2(BLANK_CYC + 1);
    localparam logic [LW-1:0] MIN_V  = LW'(FILT_MIN);
    localparam logic [LW-1:0] MAX_V  = LW'(FILT_MAX);
    localparam logic [LW-1:0] MAXM_V = LW'(FILT_MAX - 1);
    localparam logic [BW-1:0] BLK_V  = BW'(BLANK_CYC);

    logic          s1_q, s2_q;
    logic [BW-1:0] blk_q;
    logic [LW-1:0] low_q, low_d;
    logic          arm_q, arm_d;
    logic          held_q, held_d;
    logic          hit_q, hit_d;
    logic          blanked;

    // Two-flop synchroniser for the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= pin_i;
            s2_q <= s1_q;
        end
    end

    // Blanking window that outlasts the synchroniser after our own drive ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blk_q <= BLK_V;
        else if (drive_i)
            blk_q <= BLK_V;
        else if (blk_q != '0)
            blk_q <= blk_q - 1'b1;
    end

    assign blanked = drive_i || (blk_q != '0);

    // Classification of the current sample against the two thresholds.
    always_comb begin
        low_d  = low_q;
        arm_d  = arm_q;
        held_d = held_q;
        hit_d  = 1'b0;
        if (s2_q) begin
            held_d = 1'b0;
            arm_d  = 1'b1;
        end
        if (blanked) begin
            low_d = '0;
        end else if (!s2_q) begin
            if (low_q != MAX_V)
                low_d = low_q + 1'b1;
            if (arm_q && (low_q == MAXM_V)) begin
                hit_d  = 1'b1;
                held_d = 1'b1;
                arm_d  = 1'b0;
            end
        end else begin
            if (arm_q && (low_q >= MIN_V))
                hit_d = 1'b1;
            low_d = '0;
        end
    end

    // Filter state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            arm_q  <= 1'b1;
            held_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            low_q  <= low_d;
            arm_q  <= arm_d;
            held_q <= held_d;
            hit_q  <= hit_d;
        end
    end

    assign hit_o  = hit_q;
    assign held_o = held_q;

    p_no_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_i |=> !hit_q);
    p_hit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |=> !hit_q);
endmodule

// File: rtl/wrc_cause_regs.sv
// Sticky cause flags in two words with write-one-to-clear access.
// A set in the same cycle as a clear wins. Power-on loads the reset values.
module wrc_cause_regs #(
    parameter int unsigned STAT_W = 8,
    parameter logic [STAT_W-1:0] GLOB_RST = '0,
    parameter logic [STAT_W-1:0] EXC_RST  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_glob_i,
    input  logic [STAT_W-1:0] set_exc_i,
    input  logic              clr_wr,
    input  logic              clr_sel,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] glob_o,
    output logic [STAT_W-1:0] exc_o
);
    logic [STAT_W-1:0] glob_q, exc_q;
    logic [STAT_W-1:0] clr_g, clr_e;

    assign clr_g = (clr_wr && !clr_sel) ? clr_data : '0;
    assign clr_e = (clr_wr &&  clr_sel) ? clr_data : '0;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        // One sticky global flag: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                glob_q[i] <= GLOB_RST[i];
            else if (set_glob_i[i])
                glob_q[i] <= 1'b1;
            else if (clr_g[i])
                glob_q[i] <= 1'b0;
        end
        // One sticky exception flag: set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                exc_q[i] <= EXC_RST[i];
            else if (set_exc_i[i])
                exc_q[i] <= 1'b1;
            else if (clr_e[i])
                exc_q[i] <= 1'b0;
        end
    end

    assign glob_o = glob_q;
    assign exc_o  = exc_q;

    p_set_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_exc_i) |=> ((exc_q & $past(set_exc_i)) == $past(set_exc_i)));
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (((exc_q & $past(exc_q)) == $past(exc_q)) &&
                     ((glob_q & $past(glob_q)) == $past(glob_q))));
endmodule

// File: rtl/wrc_rst_sync.sv
// Reset synchroniser: asserts at once when hold_i rises, releases at the
// second rising edge after hold_i falls. rst_n is used by the checks only.
// Assumes hold_i comes straight from flops, so it does not glitch.
module wrc_rst_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    output logic sys_rst_no
);
    logic ff1_q, ff2_q;

    // Asynchronous assert, synchronous two-stage release.
    always_ff @(posedge clk or posedge hold_i) begin
        if (hold_i) begin
            ff1_q <= 1'b0;
            ff2_q <= 1'b0;
        end else begin
            ff1_q <= 1'b1;
            ff2_q <= ff1_q;
        end
    end

    assign sys_rst_no = ff2_q;

    p_release_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_no) |-> !$past(hold_i));
    p_assert_now_r12: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> !sys_rst_no);
endmodule

// File: rtl/warm_rst_ctrl.sv
// Top: warm reset controller. It merges the internal requests and the
// filtered pad, stretches the open-drain drive, records each cause and
// produces the chip-wide reset.
// Assumes one clock serves as both oscillator and peripheral clock, and the
// pad is open drain with an external pull-up.
module warm_rst_ctrl #(
    parameter int unsigned LONG_CYC  = 2228,
    parameter int unsigned SHORT_CYC = 8,
    parameter int unsigned FILT_MIN  = 100,
    parameter int unsigned FILT_MAX  = 400,
    parameter int unsigned BLANK_CYC = 4,
    parameter int unsigned STAT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_osc_fail,
    input  logic              req_pll_slip,
    input  logic              req_wdog_dbg,
    input  logic              req_cpu_test,
    input  logic              req_soft,
    input  logic              pin_in,
    output logic              pin_drv_low,
    output logic              sys_rst_n,
    input  logic              clr_wr,
    input  logic              clr_sel,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] glob_flags,
    output logic [STAT_W-1:0] exc_flags
);
    import wrc_pkg::*;

    localparam logic [STAT_W-1:0] EXC_POR = STAT_W'(1) << E_PWR;

    logic              drive, ext_hit, ext_held, trig, hold;
    logic [STAT_W-1:0] set_glob, set_exc;

    // Any internal source or an accepted external pulse starts a stretch.
    always_comb begin
        trig = req_osc_fail | req_pll_slip | req_wdog_dbg | req_cpu_test
             | req_soft | ext_hit;
    end

    // Route each cause to its own flag bit.
    always_comb begin
        set_glob         = '0;
        set_exc          = '0;
        set_glob[G_OSC]  = req_osc_fail;
        set_glob[G_PLL]  = req_pll_slip;
        set_exc[E_WDOG]  = req_wdog_dbg;
        set_exc[E_CPU]   = req_cpu_test;
        set_exc[E_SOFT]  = req_soft;
        set_exc[E_EXT]   = ext_hit;
    end

    wrc_stretch #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_i  (trig),
        .drive_o (drive)
    );

    wrc_pin_filter #(.FILT_MIN(FILT_MIN), .FILT_MAX(FILT_MAX),
                     .BLANK_CYC(BLANK_CYC)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_in),
        .drive_i (drive),
        .hit_o   (ext_hit),
        .held_o  (ext_held)
    );

    wrc_cause_regs #(.STAT_W(STAT_W), .GLOB_RST('0), .EXC_RST(EXC_POR)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_glob_i (set_glob),
        .set_exc_i  (set_exc),
        .clr_wr     (clr_wr),
        .clr_sel    (clr_sel),
        .clr_data   (clr_data),
        .glob_o     (glob_flags),
        .exc_o      (exc_flags)
    );

    assign hold = drive | ext_held;

    wrc_rst_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .sys_rst_no (sys_rst_n)
    );

    assign pin_drv_low = drive;

    p_drive_only_when_stretch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trig) && !$past(pin_drv_low)) |-> !pin_drv_low);
    p_ext_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ext_hit |=> exc_flags[E_EXT]);
endmodule

// File: tb/warm_rst_ctrl_test.sv
module warm_rst_ctrl_test;
    localparam int LONG  = 2228;
    localparam int SHORT = 8;
    localparam int NV    = 12;
    // source: 0 osc,1 pll,2 wdog,3 cpu,4 soft,5 external (len = low samples)
    localparam int V_SRC [NV] = '{0, 1, 2, 3, 4, 5, 5, 5, 5, 5, 5, 5};
    localparam int V_LEN [NV] = '{0, 0, 0, 0, 0, 20, 99, 100, 250, 399, 400, 600};
    localparam int V_OE  [NV] = '{8, 8, 8, 8, 8, 0, 0, 8, 8, 8, 8, 8};
    localparam int V_GLB [NV] = '{1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam int V_EXC [NV] = '{0, 0, 2, 4, 8, 0, 0, 16, 16, 16, 16, 16};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic       ext_low = 1'b0;
    logic       clr_wr = 1'b0, clr_sel = 1'b0;
    logic [7:0] clr_data = '0;
    logic       drv, sys_n;
    logic [7:0] glob, exc;
    wire        pin_w = ~(drv | ext_low);

    int n_run = 0, n_fail = 0;
    int c_oe = 0, c_sys = 0, c_ovl = 0;

    always #2.5 clk = ~clk;

    warm_rst_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .req_osc_fail(req[0]), .req_pll_slip(req[1]), .req_wdog_dbg(req[2]),
        .req_cpu_test(req[3]), .req_soft(req[4]),
        .pin_in(pin_w), .pin_drv_low(drv), .sys_rst_n(sys_n),
        .clr_wr(clr_wr), .clr_sel(clr_sel), .clr_data(clr_data),
        .glob_flags(glob), .exc_flags(exc)
    );

    // Sample outputs 1 ns after each rising edge.
    always begin
        @(posedge clk);
        #1;
        if (drv) c_oe++;
        if (!sys_n) c_sys++;
        if (drv && ext_low) c_ovl++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input int idx);
        @(negedge clk) req[idx] = 1'b1;
        @(negedge clk) req[idx] = 1'b0;
    endtask

    task automatic ext_pulse(input int n);
        @(negedge clk) ext_low = 1'b1;
        repeat (n) @(negedge clk);
        ext_low = 1'b0;
    endtask

    task automatic w1c(input logic sel, input logic [7:0] d);
        @(negedge clk) begin clr_wr = 1'b1; clr_sel = sel; clr_data = d; end
        @(negedge clk) clr_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int b_oe, b_sys, b_ovl;
        // Reset state (R2, R10, R12)
        repeat (4) @(negedge clk);
        check("R2 drive in reset", drv, 1);
        check("R12 sys low in reset", sys_n, 0);
        check("R10 glob reset", glob, 0);
        check("R10 exc reset power-up", exc, 1);

        // Power-on stretch with a mid-stretch request (R2, R4, R8, R12)
        b_oe = c_oe; b_sys = c_sys;
        rst_n = 1'b1;
        repeat (100) @(negedge clk);
        pulse_req(1);
        repeat (2400) @(negedge clk);
        check("R2 long stretch", c_oe - b_oe, LONG - 1);
        check("R4 request inside long stretch keeps it", c_oe - b_oe, LONG - 1);
        check("R12 sys after long stretch", c_sys - b_sys, LONG + 1);
        check("R9 pll flag", glob, 2);
        check("R8 no retrigger after own drive", drv, 0);

        // Vector walk (R1, R3, R5, R6, R7, R9, R12)
        for (int v = 0; v < NV; v++) begin
            w1c(1'b0, 8'hFF);
            w1c(1'b1, 8'hFF);
            b_oe = c_oe; b_sys = c_sys; b_ovl = c_ovl;
            if (V_SRC[v] < 5) pulse_req(V_SRC[v]);
            else ext_pulse(V_LEN[v]);
            repeat (60) @(negedge clk);
            check($sformatf("R3/R5/R6 drive cycles vec %0d", v), c_oe - b_oe, V_OE[v]);
            check($sformatf("R9 glob vec %0d", v), glob, V_GLB[v]);
            check($sformatf("R9 exc vec %0d", v), exc, V_EXC[v]);
            check($sformatf("R1 released vec %0d", v), drv, 0);
            if (V_LEN[v] < 400)
                check($sformatf("R12 sys cycles vec %0d", v), c_sys - b_sys,
                      (V_OE[v] != 0) ? SHORT + 2 : 0);
            if (V_LEN[v] == 600) begin
                check("R7 drive while held", (c_ovl - b_ovl) > 0, 1);
                check("R7 sys held until release", (c_sys - b_sys) > 150, 1);
            end else if (V_SRC[v] == 5)
                check($sformatf("R6 no drive during pulse vec %0d", v), c_ovl - b_ovl, 0);
        end

        // Overlapping requests restart the short stretch (R4)
        w1c(1'b1, 8'hFF);
        b_oe = c_oe; b_sys = c_sys;
        pulse_req(4);
        repeat (3) @(negedge clk);
        pulse_req(2);
        repeat (40) @(negedge clk);
        check("R4 restart length", c_oe - b_oe, 13);
        check("R12 sys overlapping", c_sys - b_sys, 15);
        check("R9 both flags", exc, 8'h0A);

        // Warm reset keeps flags (R10)
        w1c(1'b1, 8'hFF);
        pulse_req(4);
        ext_pulse(250);
        repeat (40) @(negedge clk);
        check("R10 sticky across warm reset", exc, 8'h18);

        // Write-one-to-clear (R11)
        w1c(1'b1, 8'h08);
        check("R11 clear one bit", exc, 8'h10);
        w1c(1'b0, 8'hFF);
        check("R11 other word untouched", exc, 8'h10);
        @(negedge clk) begin
            req[3] = 1'b1; clr_wr = 1'b1; clr_sel = 1'b1; clr_data = 8'h04;
        end
        @(negedge clk) begin req[3] = 1'b0; clr_wr = 1'b0; end
        check("R11 set wins over clear", exc, 8'h14);
        repeat (30) @(negedge clk);

        // Power-on reset clears flags (R10)
        glob[0] = glob[0];
        pulse_req(0);
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 por clears glob", glob, 0);
        check("R10 por sets power-up only", exc, 1);
        check("R2 drive during por", drv, 1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule